// File: doc/BRIEF.md
# Slow Byte-Peripheral Bridge with Oscillator Dividers

This block lets a fast 16-bit asynchronous-bus CPU reach a group of slow byte-wide peripheral chips. An address decoder outside the block raises one select per peripheral. When any select is active while the address strobe is low, a small sequencer starts. It asserts the chosen chip select one sequencer clock ahead of a long active-low read or write strobe. When the strobe ends it acknowledges the CPU. It then holds the acknowledge until the CPU releases the address strobe. The sequencer also steers an external bidirectional byte buffer that carries the low data lane (D0..D7).

The same oscillator clock drives a divider section. It produces half, third and quarter rate clocks, which give 3.072, 2.048 and 1.536 MHz from 6.144 MHz. The third-rate output keeps its duty cycle at 50%. The sequencer does not use a second clock. It advances on a clock enable that coincides with the half-rate divider, so it runs at one half the oscillator rate.

Top module: `slowbus_bridge`

## Requirements
- R1: After reset all chip selects, both strobes and the acknowledge are high, the buffer is disabled (`buf_oe_n`=1) and `buf_dir`=0.
- R2: A cycle starts when `as_n` is low and any `sel` bit is 1. The chip select of the lowest-numbered active `sel` bit goes low within 2 oscillator clocks, and only that one.
- R3: The chip select is low for exactly one sequencer clock (2 oscillator clocks) before the strobe falls, and it stays low until the cycle ends.
- R4: With `rw`=1 (read) only `per_rd_n` pulses low; with `rw`=0 (write) only `per_wr_n` pulses low. The pulse lasts STRB_LEN sequencer clocks (2*STRB_LEN oscillator clocks).
- R5: `dtack_n` falls on the same clock edge on which the strobe rises. It stays low for as long as `as_n` is low.
- R6: Holding `as_n` low with `sel` still active after the acknowledge produces no second strobe. Within 2 oscillator clocks after `as_n` rises, the chip select and `dtack_n` return high.
- R7: `buf_oe_n` is low only while a cycle is active. `buf_dir`=1 (toward the CPU) only during an active read, and otherwise 0.
- R8: `clk_div2` toggles on every oscillator clock. `clk_div4` is high for 2 clocks and low for 2 clocks.
- R9: `clk_div3` has a period of 3 oscillator clocks and is high for 1.5 of them.
- R10: Active `sel` bits while `as_n` is high start no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | CPU address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| sel | input | NPER | Decoded peripheral selects, active high |
| per_cs_n | output | NPER | Peripheral chip selects, active low |
| per_rd_n | output | 1 | Stretched read strobe, active low |
| per_wr_n | output | 1 | Stretched write strobe, active low |
| dtack_n | output | 1 | Transfer acknowledge to CPU, active low |
| buf_oe_n | output | 1 | Byte-lane buffer enable, active low |
| buf_dir | output | 1 | Buffer direction, 1 = toward CPU |
| clk_div2 | output | 1 | Oscillator / 2 |
| clk_div3 | output | 1 | Oscillator / 3, 50% duty |
| clk_div4 | output | 1 | Oscillator / 4 |

## Verification
The sequencer moves only on every second oscillator edge, so the chip select falls 1 or 2 clocks after a request, depending on where the request lands in that phase. The bench records the clock index of each edge. It checks the gaps between edges rather than absolute times: strobe after select by 2 clocks, strobe width 2*STRB_LEN clocks, and acknowledge on the clock the strobe ends. Return to idle is checked 3 clocks after the address strobe rises. The divider outputs are sampled one time unit after both clock edges, so the half-cycle step of the third-rate output can be seen.

// File: rtl/slowbus_bridge.sv
module slowbus_bridge #(
  parameter int NPER     = 3,
  parameter int STRB_LEN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_n,
  input  logic            rw,
  input  logic [NPER-1:0] sel,
  output logic [NPER-1:0] per_cs_n,
  output logic            per_rd_n,
  output logic            per_wr_n,
  output logic            dtack_n,
  output logic            buf_oe_n,
  output logic            buf_dir,
  output logic            clk_div2,
  output logic            clk_div3,
  output logic            clk_div4
);

  localparam int CW = (STRB_LEN > 1) ? $clog2(STRB_LEN) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STRB, ST_ACK} st_t;

  st_t             st;
  logic [CW-1:0]   len_q;
  logic [NPER-1:0] cs_q;
  logic            rd_q;
  logic [1:0]      div_q;
  logic [1:0]      d3_q;
  logic            d3_neg_q;
  logic [NPER-1:0] pick;
  logic            tick;

  // Oscillator dividers: one two-bit counter serves /2 and /4.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 2'd1;

  assign clk_div2 = div_q[0];
  assign clk_div4 = div_q[1];
  assign tick     = div_q[0];

  // /3 at 50%: a rising-edge modulo-3 counter plus a falling-edge copy, ORed.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              d3_q <= '0;
    else if (d3_q == 2'd2)   d3_q <= '0;
    else                     d3_q <= d3_q + 2'd1;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) d3_neg_q <= 1'b0;
    else        d3_neg_q <= (d3_q == 2'd0);

  assign clk_div3 = (d3_q == 2'd0) | d3_neg_q;

  // Lowest-numbered active select wins.
  always_comb begin
    pick = '0;
    for (int i = NPER-1; i >= 0; i--)
      if (sel[i]) pick = NPER'(1) << i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      len_q <= '0;
      cs_q  <= '0;
      rd_q  <= 1'b0;
    end else if (tick) begin
      unique case (st)
        ST_IDLE:
          if (!as_n && (|sel)) begin
            st   <= ST_SETUP;
            cs_q <= pick;
            rd_q <= rw;
          end
        ST_SETUP: begin
          st    <= ST_STRB;
          len_q <= CW'(STRB_LEN-1);
        end
        ST_STRB:
          if (len_q == '0) st <= ST_ACK;
          else             len_q <= len_q - 1'b1;
        ST_ACK:
          if (as_n) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign per_cs_n = (st == ST_IDLE) ? '1 : ~cs_q;
  assign per_rd_n = !((st == ST_STRB) &&  rd_q);
  assign per_wr_n = !((st == ST_STRB) && !rd_q);
  assign dtack_n  = (st != ST_ACK);
  assign buf_oe_n = (st == ST_IDLE);
  assign buf_dir  = (st != ST_IDLE) && rd_q;

endmodule

// File: rtl/slowbus_bridge_chk.sv
module slowbus_bridge_chk #(
  parameter int NPER = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            as_n,
  input logic [NPER-1:0] per_cs_n,
  input logic            per_rd_n,
  input logic            per_wr_n,
  input logic            dtack_n,
  input logic            buf_oe_n,
  input logic            buf_dir,
  input logic            clk_div2
);

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~per_cs_n)); // R2

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!per_rd_n && !per_wr_n)); // R4

  AST_CS_BEFORE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_rd_n) |-> !$stable(per_rd_n) && ($past(per_cs_n) != '1)); // R3

  AST_CS_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_wr_n) |-> ($past(per_cs_n) != '1)); // R3

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && !as_n) |=> !dtack_n); // R5

  AST_NO_STRB_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> (per_rd_n && per_wr_n)); // R6

  AST_DIR_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_dir |-> !buf_oe_n); // R7

  AST_DIV2_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> clk_div2 != $past(clk_div2)); // R8

endmodule

bind slowbus_bridge slowbus_bridge_chk #(.NPER(NPER)) chk_i (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .per_cs_n(per_cs_n),
  .per_rd_n(per_rd_n), .per_wr_n(per_wr_n), .dtack_n(dtack_n),
  .buf_oe_n(buf_oe_n), .buf_dir(buf_dir), .clk_div2(clk_div2)
);

// File: tb/slowbus_bridge_tb_top.sv
`timescale 1ns/1ps
module slowbus_bridge_tb_top;
  localparam int NPER = 3;
  localparam int STRB_LEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1;
  logic rw = 1'b1;
  logic [NPER-1:0] sel = '0;
  logic [NPER-1:0] per_cs_n;
  logic per_rd_n, per_wr_n, dtack_n, buf_oe_n, buf_dir;
  logic clk_div2, clk_div3, clk_div4;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  slowbus_bridge #(.NPER(NPER), .STRB_LEN(STRB_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw(rw), .sel(sel),
    .per_cs_n(per_cs_n), .per_rd_n(per_rd_n), .per_wr_n(per_wr_n),
    .dtack_n(dtack_n), .buf_oe_n(buf_oe_n), .buf_dir(buf_dir),
    .clk_div2(clk_div2), .clk_div3(clk_div3), .clk_div4(clk_div4));

  // {sel, rw, expected cs_n, expected dir}
  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{
    {3'b001, 1'b1, 3'b110, 1'b1},
    {3'b010, 1'b0, 3'b101, 1'b0},
    {3'b100, 1'b1, 3'b011, 1'b1},
    {3'b100, 1'b0, 3'b011, 1'b0},
    {3'b110, 1'b1, 3'b101, 1'b1},
    {3'b111, 1'b0, 3'b110, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic run_cycle(input logic [2:0] s, input logic r,
                           input logic [2:0] exp_cs, input logic exp_dir);
    int t_cs = -1, t_sf = -1, t_sr = -1, t_dk = -1;
    logic [2:0] cs_seen = 3'b111;
    logic other_fell = 0;
    logic dir_seen = 0;
    logic prev_strb = 1;
    @(negedge clk);
    as_n = 1'b0; sel = s; rw = r;
    for (int t = 1; t <= 40 && t_dk < 0; t++) begin
      logic cur;
      @(negedge clk);
      cur = r ? per_rd_n : per_wr_n;
      if (((r ? per_wr_n : per_rd_n)) == 1'b0) other_fell = 1;
      if (t_cs < 0 && per_cs_n != 3'b111) begin t_cs = t; cs_seen = per_cs_n; end
      if (t_sf < 0 && cur == 1'b0) begin t_sf = t; dir_seen = buf_dir; end
      if (t_sf >= 0 && t_sr < 0 && cur == 1'b1 && prev_strb == 1'b0) t_sr = t;
      if (dtack_n == 1'b0) t_dk = t;
      prev_strb = cur;
    end
    chk(t_cs >= 1 && t_cs <= 2, "R2 cs latency", t_cs, 2);
    chk(cs_seen == exp_cs, "R2 cs value", cs_seen, exp_cs);
    chk(t_sf - t_cs == 2, "R3 cs to strobe", t_sf - t_cs, 2);
    chk(t_sr - t_sf == 2*STRB_LEN, "R4 strobe width", t_sr - t_sf, 2*STRB_LEN);
    chk(!other_fell, "R4 wrong strobe", other_fell, 0);
    chk(t_dk == t_sr, "R5 dtack at strobe end", t_dk, t_sr);
    chk(dir_seen == exp_dir && buf_oe_n == 1'b0, "R7 buffer dir", dir_seen, exp_dir);
    // hold AS low with select active
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      chk(dtack_n == 1'b0, "R5 dtack held", dtack_n, 0);
      chk(per_rd_n && per_wr_n, "R6 no restart", {per_rd_n, per_wr_n}, 3);
    end
    as_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dtack_n == 1'b1 && per_cs_n == 3'b111, "R6 release", {dtack_n, per_cs_n}, 15);
    chk(buf_oe_n == 1'b1 && buf_dir == 1'b0, "R7 idle buffer", {buf_oe_n, buf_dir}, 2);
    // select still active with AS high
    repeat (6) begin
      @(negedge clk);
      chk(per_cs_n == 3'b111 && per_rd_n && per_wr_n, "R10 no start", per_cs_n, 7);
    end
    sel = '0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic s3 [12];
    int hi;
    repeat (3) @(negedge clk);
    chk(per_cs_n == 3'b111 && per_rd_n && per_wr_n && dtack_n, "R1 reset outputs",
        {per_cs_n, per_rd_n, per_wr_n, dtack_n}, 63);
    chk(buf_oe_n == 1'b1 && buf_dir == 1'b0, "R1 reset buffer", {buf_oe_n, buf_dir}, 2);
    rst_n = 1'b1;

    // R8 dividers
    @(negedge clk);
    for (int t = 0; t < 8; t++) begin
      logic p2, p4a;
      p2 = clk_div2;
      p4a = clk_div4;
      @(negedge clk);
      chk(clk_div2 != p2, "R8 div2 toggle", clk_div2, !p2);
      if (t % 2 == 0) begin
        logic p4b;
        p4b = clk_div4;
        @(negedge clk);
        chk(p4b != p4a && clk_div4 == p4b, "R8 div4 pattern", clk_div4, p4b);
        t++;
      end
    end

    // R9 divide-by-3 with half-clock resolution
    @(posedge clk);
    for (int k = 0; k < 12; k++) begin
      #1 s3[k] = clk_div3;
      if (k % 2 == 0) @(negedge clk); else @(posedge clk);
    end
    hi = 0;
    for (int k = 0; k < 6; k++) hi += s3[k];
    chk(hi == 3, "R9 div3 duty", hi, 3);
    for (int k = 0; k < 6; k++)
      chk(s3[k] == s3[k+6], "R9 div3 period", s3[k+6], s3[k]);

    // R10 sel with AS high before any cycle
    sel = 3'b111;
    repeat (6) @(negedge clk);
    chk(per_cs_n == 3'b111 && dtack_n, "R10 sel without AS", per_cs_n, 7);
    sel = '0;

    for (int v = 0; v < NVEC; v++)
      run_cycle(VEC[v][7:5], VEC[v][4], VEC[v][3:1], VEC[v][0]);

    // back-to-back: start on the other phase of the sequencer clock
    @(negedge clk);
    run_cycle(3'b001, 1'b0, 3'b110, 1'b0);

    summary();
  end
endmodule